// File: doc/BRIEF.md
# Runahead Mode Controller

This block steers a simple in-order retirement model through runahead pre-execution. It takes one instruction per cycle at the retirement head and keeps the architectural register file. It also drives a same-cycle load lookup port toward an external cache model. When a load at the head misses, the block does not stall. It copies the register file into a checkpoint, marks the load's destination as poisoned, and keeps consuming the instruction stream speculatively.

In runahead mode every register carries a poison bit. Poison flows from sources to destinations, so instructions that depend on the miss go nowhere. Loads and stores with clean address registers emit prefetch addresses. No register result, store or commit leaves the block while it is in this mode. When the cache model signals that the triggering miss has been filled, the block restores the checkpoint, clears all poison bits, and emits a redirect carrying the trigger's pc. Fetch then replays from the triggering load.

Instruction encoding on `ins_op`: 2'b00 no-op, 2'b01 add (rd = rs1 + rs2 + imm), 2'b10 load (address = rs1 + imm, result into rd), 2'b11 store (address = rs1 + imm, data = rs2). All registers reset to zero.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset the block is in normal mode (`ra_active` = 0) and every register reads as zero.
- R2: In normal mode an add commits rd with rs1 + rs2 + imm in the same cycle (`commit_valid`, `commit_rd`, `commit_data`).
- R3: In normal mode a load drives `ld_req_valid` with address rs1 + imm; on `ld_hit` = 1 it commits `ld_rdata` to rd in the same cycle.
- R4: In normal mode a store drives `st_valid` with address rs1 + imm and data rs2, and no prefetch is issued.
- R5: A normal-mode load with `ld_hit` = 0 commits nothing, snapshots all registers as they were before that cycle, and sets `ra_active` from the next cycle.
- R6: While `ra_active` = 1, `commit_valid` and `st_valid` stay 0.
- R7: In runahead mode the triggering load's destination is poisoned, and an add's destination poison is the OR of the poison of its two sources.
- R8: In runahead mode a load or store whose address register is clean drives `pf_valid` with address rs1 + imm. One with a poisoned address register issues no prefetch and no lookup, and a load's destination becomes poisoned.
- R9: A clean-address runahead load that hits writes `ld_rdata` to rd unpoisoned. One that misses poisons rd and neither restarts runahead nor changes the saved trigger pc.
- R10: `fill_valid` in runahead mode drives `redirect_valid` with the trigger's pc in that cycle, drops that cycle's instruction, and clears `ra_active` from the next cycle. `fill_valid` in normal mode has no effect.
- R11: After exit all registers hold their checkpointed values and every poison bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction present at the head |
| ins_pc | input | PCW | Instruction pc |
| ins_op | input | 2 | Operation code |
| ins_rd | input | log2(NREGS) | Destination register |
| ins_rs1 | input | log2(NREGS) | First source / address base |
| ins_rs2 | input | log2(NREGS) | Second source / store data |
| ins_imm | input | W | Immediate |
| ld_req_valid | output | 1 | Load lookup request |
| ld_req_addr | output | W | Load lookup address |
| ld_hit | input | 1 | Lookup hit, same cycle |
| ld_rdata | input | W | Lookup data, same cycle |
| fill_valid | input | 1 | Triggering miss has returned |
| commit_valid | output | 1 | Architectural register write |
| commit_rd | output | log2(NREGS) | Written register |
| commit_data | output | W | Written value |
| st_valid | output | 1 | Architectural store |
| st_addr | output | W | Store address |
| st_data | output | W | Store data |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | W | Prefetch address |
| redirect_valid | output | 1 | Restart fetch |
| redirect_pc | output | PCW | Restart pc (triggering load) |
| ra_active | output | 1 | Runahead mode flag |

## Verification
The assertions check on every cycle that nothing commits or stores while runahead is active and that prefetches and redirects appear only in that mode. They also check that a head miss always enters the mode, that a fill always leaves it, and that the trigger pc does not move mid-episode. They further check that poison is clear in normal mode and that snapshot and restore move the full register file. Only the bench's scenarios can show that poison follows the right dependency chains. The same holds for which independent accesses turn into prefetches, and for whether the replayed instructions see exactly the pre-miss values. The bench covers two episodes so that poison left over from the first would surface in the second.

// File: rtl/ra_pkg.sv
package ra_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_ADD   = 2'b01,
        OP_LOAD  = 2'b10,
        OP_STORE = 2'b11
    } op_e;

    typedef enum logic {
        MODE_NORMAL   = 1'b0,
        MODE_RUNAHEAD = 1'b1
    } mode_e;
endpackage

// File: rtl/ra_regstate.sv
module ra_regstate #(
    parameter int NREGS = 8,
    parameter int W     = 16,
    localparam int RIDX = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] rd_idx_a,
    input  logic [RIDX-1:0] rd_idx_b,
    output logic [W-1:0]    rd_val_a,
    output logic [W-1:0]    rd_val_b,
    output logic            rd_inv_a,
    output logic            rd_inv_b,
    input  logic            wr_en,
    input  logic [RIDX-1:0] wr_idx,
    input  logic [W-1:0]    wr_data,
    input  logic            wr_inv,
    input  logic            snap,
    input  logic            restore,
    output logic            any_inv
);
    typedef struct packed {
        logic [NREGS-1:0][W-1:0] arch;
        logic [NREGS-1:0][W-1:0] ckpt;
        logic [NREGS-1:0]        inv;
    } rs_t;

    rs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restore) begin
            st_d.arch = st_q.ckpt;
            st_d.inv  = '0;
        end else begin
            if (snap) begin
                st_d.ckpt = st_q.arch;
            end
            if (wr_en) begin
                st_d.arch[wr_idx] = wr_data;
                st_d.inv[wr_idx]  = wr_inv;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_val_a = st_q.arch[rd_idx_a];
    assign rd_val_b = st_q.arch[rd_idx_b];
    assign rd_inv_a = st_q.inv[rd_idx_a];
    assign rd_inv_b = st_q.inv[rd_idx_b];
    assign any_inv  = |st_q.inv;

    // R5: the checkpoint holds the register file as it stood before the snapshot
    assert_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snap && !restore |=> st_q.ckpt == $past(st_q.arch));

    // R11: restore brings back the checkpoint and wipes all poison
    assert_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (st_q.arch == $past(st_q.ckpt)) && (st_q.inv == '0));
endmodule

// File: rtl/ra_opnd.sv
module ra_opnd #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    input  logic [W-1:0] imm,
    output logic [W-1:0] sum,
    output logic [W-1:0] addr
);
    always_comb begin
        addr = val_a + imm;
        sum  = addr + val_b;
    end
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
    import ra_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int W     = 16,
    parameter int PCW   = 16,
    localparam int RIDX = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_valid,
    input  logic [PCW-1:0]  ins_pc,
    input  logic [1:0]      ins_op,
    input  logic [RIDX-1:0] ins_rd,
    input  logic [RIDX-1:0] ins_rs1,
    input  logic [RIDX-1:0] ins_rs2,
    input  logic [W-1:0]    ins_imm,
    output logic            ld_req_valid,
    output logic [W-1:0]    ld_req_addr,
    input  logic            ld_hit,
    input  logic [W-1:0]    ld_rdata,
    input  logic            fill_valid,
    output logic            commit_valid,
    output logic [RIDX-1:0] commit_rd,
    output logic [W-1:0]    commit_data,
    output logic            st_valid,
    output logic [W-1:0]    st_addr,
    output logic [W-1:0]    st_data,
    output logic            pf_valid,
    output logic [W-1:0]    pf_addr,
    output logic            redirect_valid,
    output logic [PCW-1:0]  redirect_pc,
    output logic            ra_active
);
    typedef struct packed {
        mode_e          mode;
        logic [PCW-1:0] trig_pc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    op_e          op;
    logic [W-1:0] val_a, val_b, sum, addr;
    logic         inv_a, inv_b, any_inv;
    logic         wr_en, wr_inv, snap, restore;
    logic [W-1:0] wr_data;

    assign op = op_e'(ins_op);

    ra_regstate #(.NREGS(NREGS), .W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_a (ins_rs1),
        .rd_idx_b (ins_rs2),
        .rd_val_a (val_a),
        .rd_val_b (val_b),
        .rd_inv_a (inv_a),
        .rd_inv_b (inv_b),
        .wr_en    (wr_en),
        .wr_idx   (ins_rd),
        .wr_data  (wr_data),
        .wr_inv   (wr_inv),
        .snap     (snap),
        .restore  (restore),
        .any_inv  (any_inv)
    );

    ra_opnd #(.W(W)) u_opnd (
        .val_a (val_a),
        .val_b (val_b),
        .imm   (ins_imm),
        .sum   (sum),
        .addr  (addr)
    );

    always_comb begin
        ctl_d          = ctl_q;
        wr_en          = 1'b0;
        wr_inv         = 1'b0;
        wr_data        = '0;
        snap           = 1'b0;
        restore        = 1'b0;
        ld_req_valid   = 1'b0;
        commit_valid   = 1'b0;
        st_valid       = 1'b0;
        pf_valid       = 1'b0;
        redirect_valid = 1'b0;

        if (ctl_q.mode == MODE_NORMAL) begin
            if (ins_valid) begin
                unique case (op)
                    OP_ADD: begin
                        wr_en        = 1'b1;
                        wr_data      = sum;
                        commit_valid = 1'b1;
                    end
                    OP_LOAD: begin
                        ld_req_valid = 1'b1;
                        if (ld_hit) begin
                            wr_en        = 1'b1;
                            wr_data      = ld_rdata;
                            commit_valid = 1'b1;
                        end else begin
                            snap          = 1'b1;
                            wr_en         = 1'b1;
                            wr_inv        = 1'b1;
                            ctl_d.mode    = MODE_RUNAHEAD;
                            ctl_d.trig_pc = ins_pc;
                        end
                    end
                    OP_STORE: st_valid = 1'b1;
                    default: ;
                endcase
            end
        end else if (fill_valid) begin
            restore        = 1'b1;
            redirect_valid = 1'b1;
            ctl_d.mode     = MODE_NORMAL;
        end else if (ins_valid) begin
            unique case (op)
                OP_ADD: begin
                    wr_en   = 1'b1;
                    wr_data = sum;
                    wr_inv  = inv_a | inv_b;
                end
                OP_LOAD: begin
                    wr_en = 1'b1;
                    if (inv_a) begin
                        wr_inv = 1'b1;
                    end else begin
                        ld_req_valid = 1'b1;
                        pf_valid     = 1'b1;
                        wr_data      = ld_rdata;
                        wr_inv       = !ld_hit;
                    end
                end
                OP_STORE: pf_valid = !inv_a;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{mode: MODE_NORMAL, trig_pc: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ld_req_addr = addr;
    assign commit_rd   = ins_rd;
    assign commit_data = wr_data;
    assign st_addr     = addr;
    assign st_data     = val_b;
    assign pf_addr     = addr;
    assign redirect_pc = ctl_q.trig_pc;
    assign ra_active   = (ctl_q.mode == MODE_RUNAHEAD);

    // R6: no architectural side effect escapes while speculating
    assert_no_commit_in_ra_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ra_active |-> !commit_valid && !st_valid);

    // R4 and R8: prefetches only come out of runahead mode
    assert_pf_only_ra_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> ra_active);

    // R5: a head miss in normal mode always enters runahead
    assert_enter_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ra_active && ins_valid && ins_op == 2'b10 && !ld_hit) |=> ra_active);

    // R10: a fill while speculating always returns to normal mode
    assert_exit_on_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_active && fill_valid) |=> !ra_active);

    // R10: redirects are only issued from runahead mode
    assert_redirect_in_ra_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> ra_active);

    // R9: later misses never move the saved trigger pc
    assert_trig_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_active && !fill_valid) |=> $stable(redirect_pc));

    // R11: poison never survives into normal mode
    assert_inv_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_active |-> !any_inv);
endmodule

// File: tb/runahead_ctrl_bench.sv
module runahead_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;
    localparam int WD = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ins_valid = 1'b0;
    logic [15:0]     ins_pc = '0;
    logic [1:0]      ins_op = '0;
    logic [2:0]      ins_rd = '0, ins_rs1 = '0, ins_rs2 = '0;
    logic [WD-1:0]   ins_imm = '0;
    logic            ld_req_valid;
    logic [WD-1:0]   ld_req_addr;
    logic            ld_hit = 1'b0;
    logic [WD-1:0]   ld_rdata = '0;
    logic            fill_valid = 1'b0;
    logic            commit_valid;
    logic [2:0]      commit_rd;
    logic [WD-1:0]   commit_data;
    logic            st_valid;
    logic [WD-1:0]   st_addr, st_data;
    logic            pf_valid;
    logic [WD-1:0]   pf_addr;
    logic            redirect_valid;
    logic [15:0]     redirect_pc;
    logic            ra_active;

    int vectors = 0;
    int errors  = 0;

    // behavioural reference state
    logic [WD-1:0] ref_rf [NR];
    logic [WD-1:0] ref_ck [NR];
    bit            ref_inv [NR];
    bit            ref_ra;
    logic [15:0]   ref_trig;

    always #(CLK_PERIOD/2) clk = ~clk;

    runahead_ctrl #(.NREGS(NR), .W(WD), .PCW(16)) u_runahead_ctrl (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pc(ins_pc),
        .ins_op(ins_op), .ins_rd(ins_rd), .ins_rs1(ins_rs1), .ins_rs2(ins_rs2),
        .ins_imm(ins_imm), .ld_req_valid(ld_req_valid), .ld_req_addr(ld_req_addr),
        .ld_hit(ld_hit), .ld_rdata(ld_rdata), .fill_valid(fill_valid),
        .commit_valid(commit_valid), .commit_rd(commit_rd), .commit_data(commit_data),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .ra_active(ra_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one instruction slot; fill flag models the return of the triggering miss
    task automatic step(input bit v, input logic [1:0] op, input int rd, input int rs1,
                        input int rs2, input logic [WD-1:0] imm, input logic [15:0] pc,
                        input bit hit, input bit fill);
        logic [WD-1:0] a, b, sum, addr, rdata;
        bit ia, ib;
        bit e_commit, e_st, e_pf, e_req, e_redir;
        logic [WD-1:0] e_cdata;
        @(negedge clk);
        ins_valid = v; ins_op = op; ins_rd = 3'(rd); ins_rs1 = 3'(rs1);
        ins_rs2 = 3'(rs2); ins_imm = imm; ins_pc = pc; fill_valid = fill;
        a = ref_rf[rs1]; b = ref_rf[rs2]; ia = ref_inv[rs1]; ib = ref_inv[rs2];
        addr = a + imm; sum = a + b + imm; rdata = addr * 16'd3 + 16'd7;
        ld_hit = hit; ld_rdata = rdata;
        e_commit = 0; e_st = 0; e_pf = 0; e_req = 0; e_redir = 0; e_cdata = '0;
        if (!ref_ra) begin
            if (v && op == 2'b01) begin e_commit = 1; e_cdata = sum; end
            if (v && op == 2'b10) begin
                e_req = 1;
                if (hit) begin e_commit = 1; e_cdata = rdata; end
            end
            if (v && op == 2'b11) e_st = 1;
        end else if (fill) begin
            e_redir = 1;
        end else if (v) begin
            if (op == 2'b10 && !ia) begin e_req = 1; e_pf = 1; end
            if (op == 2'b11 && !ia) e_pf = 1;
        end
        #1;
        chk("R1 R5 R10 ra_active", ra_active, ref_ra);
        chk("R2 R3 R6 commit_valid", commit_valid, e_commit);
        if (e_commit) begin
            chk("R2 R3 R11 commit_rd", commit_rd, rd);
            chk("R2 R3 R11 commit_data", commit_data, e_cdata);
        end
        chk("R4 R6 st_valid", st_valid, e_st);
        if (e_st) begin
            chk("R4 st_addr", st_addr, addr);
            chk("R4 st_data", st_data, b);
        end
        chk("R7 R8 R9 pf_valid", pf_valid, e_pf);
        if (e_pf) chk("R8 pf_addr", pf_addr, addr);
        chk("R3 R8 ld_req_valid", ld_req_valid, e_req);
        if (e_req) chk("R3 R8 ld_req_addr", ld_req_addr, addr);
        chk("R10 redirect_valid", redirect_valid, e_redir);
        if (e_redir) chk("R10 redirect_pc", redirect_pc, ref_trig);
        // reference state update
        if (!ref_ra) begin
            if (v && op == 2'b01) ref_rf[rd] = sum;
            if (v && op == 2'b10) begin
                if (hit) ref_rf[rd] = rdata;
                else begin
                    for (int i = 0; i < NR; i++) ref_ck[i] = ref_rf[i];
                    ref_inv[rd] = 1; ref_ra = 1; ref_trig = pc;
                end
            end
        end else if (fill) begin
            for (int i = 0; i < NR; i++) begin ref_rf[i] = ref_ck[i]; ref_inv[i] = 0; end
            ref_ra = 0;
        end else if (v) begin
            if (op == 2'b01) begin ref_rf[rd] = sum; ref_inv[rd] = ia | ib; end
            if (op == 2'b10) begin
                if (ia) ref_inv[rd] = 1;
                else begin ref_rf[rd] = rdata; ref_inv[rd] = !hit; end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin ref_rf[i] = '0; ref_ck[i] = '0; ref_inv[i] = 0; end
        ref_ra = 0; ref_trig = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state, registers read zero
        step(1, 2'b01, 6, 0, 7, 16'd0, 16'd0, 0, 0);
        // R2: build constants
        step(1, 2'b01, 1, 0, 0, 16'd5, 16'd1, 0, 0);
        step(1, 2'b01, 2, 1, 1, 16'd1, 16'd2, 0, 0);
        step(1, 2'b01, 3, 2, 1, 16'd0, 16'd3, 0, 0);
        step(1, 2'b01, 4, 0, 0, 16'd100, 16'd4, 0, 0);
        // R3: load hit
        step(1, 2'b10, 5, 4, 0, 16'd4, 16'd5, 1, 0);
        // R4: store
        step(1, 2'b11, 0, 1, 3, 16'd2, 16'd6, 0, 0);
        step(0, 2'b00, 0, 0, 0, 16'd0, 16'd7, 0, 0);
        // R10: fill in normal mode has no effect
        step(1, 2'b01, 7, 3, 4, 16'd1, 16'd8, 0, 1);
        // R5: head miss enters runahead
        step(1, 2'b10, 6, 2, 0, 16'd0, 16'd20, 0, 0);
        // R7: poison flows through add
        step(1, 2'b01, 7, 6, 1, 16'd0, 16'd21, 0, 0);
        // R8: poisoned address, no prefetch, dest poisoned
        step(1, 2'b10, 3, 7, 0, 16'd1, 16'd22, 1, 0);
        // R9: clean load hit
        step(1, 2'b10, 2, 1, 0, 16'd3, 16'd23, 1, 0);
        // R8: store with poisoned base, then clean base
        step(1, 2'b11, 0, 3, 1, 16'd0, 16'd24, 0, 0);
        step(1, 2'b11, 0, 1, 7, 16'd9, 16'd25, 0, 0);
        // R9: second miss, no restart
        step(1, 2'b10, 4, 4, 0, 16'd0, 16'd26, 0, 0);
        step(1, 2'b01, 1, 4, 0, 16'd0, 16'd27, 0, 0);
        step(1, 2'b10, 5, 1, 0, 16'd0, 16'd28, 1, 0);
        step(1, 2'b10, 5, 2, 0, 16'd2, 16'd29, 1, 0);
        // R10: fill drops the instruction, redirects to 20
        step(1, 2'b01, 5, 2, 2, 16'd0, 16'd30, 0, 1);
        // R11: replay sees the checkpoint
        step(1, 2'b10, 6, 2, 0, 16'd0, 16'd20, 1, 0);
        step(1, 2'b01, 0, 1, 0, 16'd0, 16'd21, 0, 0);
        step(1, 2'b01, 0, 2, 0, 16'd0, 16'd22, 0, 0);
        step(1, 2'b01, 0, 3, 0, 16'd0, 16'd23, 0, 0);
        step(1, 2'b01, 0, 4, 7, 16'd0, 16'd24, 0, 0);
        step(1, 2'b01, 0, 5, 0, 16'd0, 16'd25, 0, 0);
        // second episode: poison from the first must be gone (R11)
        step(1, 2'b10, 1, 0, 0, 16'd50, 16'd40, 0, 0);
        step(1, 2'b10, 5, 3, 0, 16'd0, 16'd41, 1, 0);
        step(1, 2'b11, 0, 7, 1, 16'd4, 16'd42, 0, 0);
        step(1, 2'b10, 6, 1, 0, 16'd0, 16'd43, 1, 0);
        step(0, 2'b00, 0, 0, 0, 16'd0, 16'd44, 0, 1);
        step(1, 2'b10, 1, 0, 0, 16'd50, 16'd40, 1, 0);
        step(1, 2'b01, 0, 5, 6, 16'd0, 16'd41, 0, 0);
        step(1, 2'b11, 0, 1, 5, 16'd0, 16'd42, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule